// File: doc/BRIEF.md
# Clock Root Configuration Register Block

This block is the register front end of a clock root. Software programs a pending set of root settings: a configuration word holding pre-divider, source select, mode and a hardware-control flag, plus the M, N and D values of the fractional divider. None of these settings reaches the root outputs until software writes the update command. The block then takes a snapshot of the pending set and moves it into the active set a fixed number of cycles later. The update bit clears itself when that happens. Per-register change flags tell software which pending registers have been written since the last commit began.

A table of eight performance levels, each holding a configuration word, an M value and an N value, can take over the active settings. Level mode is switched on, and a level chosen, through one control word. While it is on with a valid index, the root outputs follow the chosen table entry and D keeps its committed value. The command word also carries a force-on bit and a read-only root-off status bit, which reflects both the force bit and an enable request from the clock consumer. The divider itself and the glitch-free source switch sit downstream and are not part of this block.

Top module: `clkroot_csr`

## Requirements
- R1: After synchronous reset every stored register is zero and all root outputs are zero. The command word reads 0x8000_0000 while `clk_req` is low.
- R2: Command bits 4, 5, 6 and 7 are change flags for the pending configuration, N, M and D registers. Each flag sets when its register is written. All four clear in the cycle a commit starts, and writes to the command word cannot change them.
- R3: Command bit 0 (update) starts a commit when written as 1 while idle. It then reads 1 until the commit completes and reads 0 afterwards. Writing 1 again while a commit is in progress neither restarts nor extends it.
- R4: A commit copies the pending configuration, M, N and D values that were present at the clock edge that captured the update write. The copy reaches the active set exactly 4 clock edges after that edge, and the active set does not change before then.
- R5: Pending writes made while a commit is in progress do not enter that commit. They stay pending, set their change flag, and are applied by the next commit.
- R6: Command bit 1 is a stored force-on bit. Command bit 31 reads 0 when force-on is set or `clk_req` is high, and reads 1 otherwise. Bit 31 cannot be written.
- R7: The configuration word at 0x04 keeps the pre-divider in bits 4:0, the source select in bits 10:8, the mode in bits 13:12 and the hardware-control flag in bit 20. All other bits read 0. The root outputs take source, pre-divider and mode from the active configuration.
- R8: The level control word at 0x14 holds the level-mode enable in bit 0 and a 4-bit level index in bits 4:1. It reads back these five bits and zero elsewhere.
- R9: Level L (0 to 7) has a configuration word at 0x1C+4L, masked like R7, an M value at 0x5C+4L and an N value at 0x9C+4L. M and N keep their low 8 bits.
- R10: While level mode is enabled and the index is below 8, the root source, pre-divider, mode, M and N come from that level's entries, and D stays at the committed value. The change takes effect in the cycle after the control write.
- R11: While level mode is enabled with an index of 8 to 15, or while it is disabled, all root outputs come from the committed active set.
- R12: Addresses outside the map read as zero, and writes to them change no register and no output.
- R13: The pending M, N and D registers at 0x08, 0x0C and 0x10 keep the low 8 bits of the written data and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_req | input | 1 | Enable request from the clock consumer |
| root_src | output | 3 | Effective source select |
| root_pdiv | output | 5 | Effective pre-divider |
| root_mode | output | 2 | Effective divider mode |
| root_m | output | 8 | Effective M value |
| root_n | output | 8 | Effective N value |
| root_d | output | 8 | Committed D value |

## Verification
The assertions assume the bus issues at most one write per cycle. They also assume the address decode is byte-aligned, so the word offsets in the map are the only ones that hit a register. The bench drives a single write per cycle, with inputs changed on the falling edge. Its random writes can land on any 4-byte-aligned address except the command word. Update commands are issued only from directed sequences and from a commit routine that waits out the full window, which keeps the bench's view of the busy state exact.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    localparam int PDIV_W        = 5;
    localparam int SRC_W         = 3;
    localparam int MODE_W        = 2;
    localparam int MND_W         = 8;
    localparam int IDX_W         = 4;
    localparam int LVL_COUNT     = 8;
    localparam int COMMIT_CYCLES = 4;

    localparam int SRC_LSB  = 8;
    localparam int MODE_LSB = 12;
    localparam int HWC_BIT  = 20;

    localparam logic [7:0] A_CMD  = 8'h00;
    localparam logic [7:0] A_CFG  = 8'h04;
    localparam logic [7:0] A_MVAL = 8'h08;
    localparam logic [7:0] A_NVAL = 8'h0C;
    localparam logic [7:0] A_DVAL = 8'h10;
    localparam logic [7:0] A_LVL  = 8'h14;
    localparam logic [7:0] A_TCFG = 8'h1C;
    localparam logic [7:0] A_TM   = 8'h5C;
    localparam logic [7:0] A_TN   = 8'h9C;

    typedef enum logic [1:0] {
        TK_CFG  = 2'd0,
        TK_M    = 2'd1,
        TK_N    = 2'd2,
        TK_NONE = 2'd3
    } tbl_kind_e;

    typedef struct packed {
        logic              hwc;
        logic [MODE_W-1:0] mode;
        logic [SRC_W-1:0]  src;
        logic [PDIV_W-1:0] pdiv;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        logic [MND_W-1:0] m;
        logic [MND_W-1:0] n;
        logic [MND_W-1:0] d;
    } root_set_t;

    function automatic cfg_t cfg_from_word(logic [31:0] w);
        cfg_t c;
        c.pdiv = w[PDIV_W-1:0];
        c.src  = w[SRC_LSB +: SRC_W];
        c.mode = w[MODE_LSB +: MODE_W];
        c.hwc  = w[HWC_BIT];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(cfg_t c);
        logic [31:0] w;
        w = '0;
        w[PDIV_W-1:0]          = c.pdiv;
        w[SRC_LSB +: SRC_W]    = c.src;
        w[MODE_LSB +: MODE_W]  = c.mode;
        w[HWC_BIT]             = c.hwc;
        return w;
    endfunction

    function automatic logic in_table(logic [7:0] a, logic [7:0] base, int n);
        return (a >= base) && (int'(a) < int'(base) + 4 * n) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] table_slot(logic [7:0] a, logic [7:0] base);
        return (a - base) >> 2;
    endfunction

endpackage

// File: rtl/clkroot_commit.sv
module clkroot_commit
    import clkroot_pkg::*;
#(
    parameter int LAT = COMMIT_CYCLES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  root_set_t pend,
    output logic      busy,
    output root_set_t active
);
    localparam int CW = $clog2(LAT + 1);

    root_set_t       stage;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            stage  <= '0;
            active <= '0;
        end else if (busy) begin
            if (cnt == '0) begin
                active <= stage;
                busy   <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (start) begin
            stage <= pend;
            busy  <= 1'b1;
            cnt   <= CW'(LAT - 1);
        end
    end

    // Independent window counter for the checks below
    logic [CW-1:0] win;
    always_ff @(posedge clk) begin
        if (rst || !busy) win <= '0;
        else              win <= win + 1'b1;
    end

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

    assert_window_len_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(win) < LAT));

    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        busy && (int'(win) == LAT - 1) |=> !busy);

    assert_active_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(busy && cnt == '0) |=> $stable(active));

endmodule

// File: rtl/clkroot_lvl_tbl.sv
module clkroot_lvl_tbl
    import clkroot_pkg::*;
#(
    parameter int LEVELS = LVL_COUNT,
    localparam int LW = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  tbl_kind_e        wr_kind,
    input  logic [LW-1:0]    wr_idx,
    input  logic [31:0]      wdata,
    input  tbl_kind_e        rd_kind,
    input  logic [LW-1:0]    rd_idx,
    output logic [31:0]      rdata,
    input  logic [LW-1:0]    sel_idx,
    output cfg_t             sel_cfg,
    output logic [MND_W-1:0] sel_m,
    output logic [MND_W-1:0] sel_n
);
    cfg_t             ent_cfg [LEVELS];
    logic [MND_W-1:0] ent_m   [LEVELS];
    logic [MND_W-1:0] ent_n   [LEVELS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LEVELS; i++) begin
            if (rst) begin
                ent_cfg[i] <= '0;
                ent_m[i]   <= '0;
                ent_n[i]   <= '0;
            end else if (wr_en && wr_idx == LW'(i)) begin
                case (wr_kind)
                    TK_CFG:  ent_cfg[i] <= cfg_from_word(wdata);
                    TK_M:    ent_m[i]   <= wdata[MND_W-1:0];
                    TK_N:    ent_n[i]   <= wdata[MND_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_kind)
            TK_CFG:  rdata = cfg_to_word(ent_cfg[rd_idx]);
            TK_M:    rdata = 32'(ent_m[rd_idx]);
            TK_N:    rdata = 32'(ent_n[rd_idx]);
            default: rdata = '0;
        endcase
    end

    assign sel_cfg = ent_cfg[sel_idx];
    assign sel_m   = ent_m[sel_idx];
    assign sel_n   = ent_n[sel_idx];

endmodule

// File: rtl/clkroot_csr.sv
module clkroot_csr
    import clkroot_pkg::*;
#(
    parameter int LEVELS     = LVL_COUNT,
    parameter int COMMIT_LAT = COMMIT_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              clk_req,
    output logic [SRC_W-1:0]  root_src,
    output logic [PDIV_W-1:0] root_pdiv,
    output logic [MODE_W-1:0] root_mode,
    output logic [MND_W-1:0]  root_m,
    output logic [MND_W-1:0]  root_n,
    output logic [MND_W-1:0]  root_d
);
    localparam int LW = $clog2(LEVELS);

    root_set_t        pend;
    root_set_t        active;
    logic             busy;
    logic             force_on;
    logic [3:0]       dirty;      // {D, M, N, CFG}
    logic             lvl_en;
    logic [IDX_W-1:0] lvl_idx;

    // Address decode
    logic wr_cmd, wr_cfg, wr_m, wr_n, wr_d, wr_lvl, start;
    assign wr_cmd = bus_wen && (bus_addr == A_CMD);
    assign wr_cfg = bus_wen && (bus_addr == A_CFG);
    assign wr_m   = bus_wen && (bus_addr == A_MVAL);
    assign wr_n   = bus_wen && (bus_addr == A_NVAL);
    assign wr_d   = bus_wen && (bus_addr == A_DVAL);
    assign wr_lvl = bus_wen && (bus_addr == A_LVL);
    assign start  = wr_cmd && bus_wdata[0] && !busy;

    tbl_kind_e   addr_kind;
    logic [7:0]  addr_slot;
    always_comb begin
        addr_kind = TK_NONE;
        addr_slot = '0;
        if (in_table(bus_addr, A_TCFG, LEVELS)) begin
            addr_kind = TK_CFG;
            addr_slot = table_slot(bus_addr, A_TCFG);
        end else if (in_table(bus_addr, A_TM, LEVELS)) begin
            addr_kind = TK_M;
            addr_slot = table_slot(bus_addr, A_TM);
        end else if (in_table(bus_addr, A_TN, LEVELS)) begin
            addr_kind = TK_N;
            addr_slot = table_slot(bus_addr, A_TN);
        end
    end

    // Pending set, command and level control
    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            force_on <= 1'b0;
            dirty    <= '0;
            lvl_en   <= 1'b0;
            lvl_idx  <= '0;
        end else begin
            if (wr_cfg) pend.cfg <= cfg_from_word(bus_wdata);
            if (wr_m)   pend.m   <= bus_wdata[MND_W-1:0];
            if (wr_n)   pend.n   <= bus_wdata[MND_W-1:0];
            if (wr_d)   pend.d   <= bus_wdata[MND_W-1:0];
            if (wr_cmd) force_on <= bus_wdata[1];
            if (wr_lvl) begin
                lvl_en  <= bus_wdata[0];
                lvl_idx <= bus_wdata[IDX_W:1];
            end
            if (start) dirty <= '0;
            else       dirty <= dirty | {wr_d, wr_m, wr_n, wr_cfg};
        end
    end

    clkroot_commit #(.LAT(COMMIT_LAT)) i_commit (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .pend   (pend),
        .busy   (busy),
        .active (active)
    );

    logic [31:0]      tbl_rdata;
    cfg_t             tbl_cfg;
    logic [MND_W-1:0] tbl_m, tbl_n;

    clkroot_lvl_tbl #(.LEVELS(LEVELS)) i_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wen && addr_kind != TK_NONE),
        .wr_kind (addr_kind),
        .wr_idx  (addr_slot[LW-1:0]),
        .wdata   (bus_wdata),
        .rd_kind (addr_kind),
        .rd_idx  (addr_slot[LW-1:0]),
        .rdata   (tbl_rdata),
        .sel_idx (lvl_idx[LW-1:0]),
        .sel_cfg (tbl_cfg),
        .sel_m   (tbl_m),
        .sel_n   (tbl_n)
    );

    // Read-back
    logic root_off;
    assign root_off = !(force_on || clk_req);

    always_comb begin
        bus_rdata = '0;
        if (addr_kind != TK_NONE)    bus_rdata = tbl_rdata;
        else if (bus_addr == A_CMD)  bus_rdata = {root_off, 23'b0, dirty, 2'b0, force_on, busy};
        else if (bus_addr == A_CFG)  bus_rdata = cfg_to_word(pend.cfg);
        else if (bus_addr == A_MVAL) bus_rdata = 32'(pend.m);
        else if (bus_addr == A_NVAL) bus_rdata = 32'(pend.n);
        else if (bus_addr == A_DVAL) bus_rdata = 32'(pend.d);
        else if (bus_addr == A_LVL)  bus_rdata = 32'({lvl_idx, lvl_en});
    end

    // Effective root settings
    logic use_lvl;
    cfg_t eff_cfg;
    assign use_lvl   = lvl_en && (int'(lvl_idx) < LEVELS);
    assign eff_cfg   = use_lvl ? tbl_cfg : active.cfg;
    assign root_src  = eff_cfg.src;
    assign root_pdiv = eff_cfg.pdiv;
    assign root_mode = eff_cfg.mode;
    assign root_m    = use_lvl ? tbl_m : active.m;
    assign root_n    = use_lvl ? tbl_n : active.n;
    assign root_d    = active.d;

    assert_dirty_set_R2: assert property (@(posedge clk) disable iff (rst)
        bus_wen && bus_addr == A_MVAL |=> dirty[2]);

    assert_force_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(bus_wen && bus_addr == A_CMD) |=> $stable(force_on));

endmodule

// File: tb/test_clkroot_csr.sv
module test_clkroot_csr;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wen;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        clk_req;
    logic [2:0]  root_src;
    logic [4:0]  root_pdiv;
    logic [1:0]  root_mode;
    logic [7:0]  root_m, root_n, root_d;

    always #5 clk = ~clk;

    clkroot_csr i_clkroot_csr (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_req(clk_req),
        .root_src(root_src), .root_pdiv(root_pdiv), .root_mode(root_mode),
        .root_m(root_m), .root_n(root_n), .root_d(root_d)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Bench model
    logic [31:0] p_cfg, a_cfg, s_cfg;
    logic [7:0]  p_m, p_n, p_d, a_m, a_n, a_d, s_m, s_n, s_d;
    logic [31:0] t_cfg [8];
    logic [7:0]  t_m [8];
    logic [7:0]  t_n [8];
    logic [4:0]  m_lvl;
    logic        m_force;
    logic [3:0]  m_dirty;

    function automatic logic [31:0] cmask(logic [31:0] w);
        return w & 32'h0010_371F;
    endfunction

    function automatic logic [63:0] exp_outs();
        logic [31:0] c;
        logic [7:0]  m, n;
        logic        use_l;
        use_l = m_lvl[0] && (m_lvl[4:1] < 5'd8);
        c = use_l ? t_cfg[m_lvl[3:1]] : a_cfg;
        m = use_l ? t_m[m_lvl[3:1]] : a_m;
        n = use_l ? t_n[m_lvl[3:1]] : a_n;
        return {30'b0, c[10:8], c[4:0], c[13:12], m, n, a_d};
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        if (a == 8'h00) return {~(m_force | clk_req), 23'b0, m_dirty, 2'b0, m_force, 1'b0};
        if (a == 8'h04) return p_cfg;
        if (a == 8'h08) return {24'b0, p_m};
        if (a == 8'h0C) return {24'b0, p_n};
        if (a == 8'h10) return {24'b0, p_d};
        if (a == 8'h14) return {27'b0, m_lvl};
        if (a[1:0] == 2'b00 && a >= 8'h1C && a < 8'h3C) return t_cfg[(a - 8'h1C) >> 2];
        if (a[1:0] == 2'b00 && a >= 8'h5C && a < 8'h7C) return {24'b0, t_m[(a - 8'h5C) >> 2]};
        if (a[1:0] == 2'b00 && a >= 8'h9C && a < 8'hBC) return {24'b0, t_n[(a - 8'h9C) >> 2]};
        return 32'h0;
    endfunction

    function automatic void m_apply(logic [7:0] a, logic [31:0] d);
        if (a == 8'h00) m_force = d[1];
        else if (a == 8'h04) begin p_cfg = cmask(d); m_dirty[0] = 1'b1; end
        else if (a == 8'h0C) begin p_n = d[7:0]; m_dirty[1] = 1'b1; end
        else if (a == 8'h08) begin p_m = d[7:0]; m_dirty[2] = 1'b1; end
        else if (a == 8'h10) begin p_d = d[7:0]; m_dirty[3] = 1'b1; end
        else if (a == 8'h14) m_lvl = d[4:0];
        else if (a[1:0] == 2'b00 && a >= 8'h1C && a < 8'h3C) t_cfg[(a - 8'h1C) >> 2] = cmask(d);
        else if (a[1:0] == 2'b00 && a >= 8'h5C && a < 8'h7C) t_m[(a - 8'h5C) >> 2] = d[7:0];
        else if (a[1:0] == 2'b00 && a >= 8'h9C && a < 8'hBC) t_n[(a - 8'h9C) >> 2] = d[7:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive during the low phase; captured at the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic mwr(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        m_apply(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_rd(input string tag, input logic [7:0] a);
        logic [31:0] v;
        rd(a, v);
        check(tag, {32'b0, v}, {32'b0, exp_rd(a)});
    endtask

    task automatic check_outs(input string tag);
        check(tag, {30'b0, root_src, root_pdiv, root_mode, root_m, root_n, root_d}, exp_outs());
    endtask

    task automatic commit_full();
        wr(8'h00, {30'b0, m_force, 1'b1});
        s_cfg = p_cfg; s_m = p_m; s_n = p_n; s_d = p_d; m_dirty = 4'b0;
        repeat (4) @(negedge clk);
        a_cfg = s_cfg; a_m = s_m; a_n = s_n; a_d = s_d;
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        rst = 1'b1; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0; clk_req = 1'b0;
        p_cfg = 0; a_cfg = 0; p_m = 0; p_n = 0; p_d = 0; a_m = 0; a_n = 0; a_d = 0;
        for (int i = 0; i < 8; i++) begin t_cfg[i] = 0; t_m[i] = 0; t_n[i] = 0; end
        m_lvl = 0; m_force = 0; m_dirty = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, v); check("R1 cmd reset", {32'b0, v}, 64'h8000_0000);
        check_rd("R1 cfg reset", 8'h04);
        check_rd("R1 lvl reset", 8'h14);
        check_outs("R1 outputs reset");

        // R7, R13 masking; R2 flags
        mwr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); check("R7 cfg mask", {32'b0, v}, 64'h0010_371F);
        rd(8'h00, v); check("R2 cfg flag", {32'b0, v}, 64'h8000_0010);
        mwr(8'h08, 32'h0000_01A5); check_rd("R13 M mask", 8'h08);
        mwr(8'h0C, 32'hABCD_0033); check_rd("R13 N mask", 8'h0C);
        mwr(8'h10, 32'h0000_0F5C); check_rd("R13 D mask", 8'h10);
        mwr(8'h00, 32'h0000_00F0);
        rd(8'h00, v); check("R2 flags not writable", {32'b0, v}, 64'h8000_00F0);
        check_outs("R4 pending not yet active");

        // R3, R4 commit timing
        wr(8'h00, 32'h1);
        s_cfg = p_cfg; s_m = p_m; s_n = p_n; s_d = p_d; m_dirty = 0;
        rd(8'h00, v); check("R3 update reads 1, R2 flags cleared", {32'b0, v}, 64'h8000_0001);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check_outs("R4 active held during window");
        end
        @(negedge clk);
        a_cfg = s_cfg; a_m = s_m; a_n = s_n; a_d = s_d;
        check_outs("R4 active after 4 edges, R7 fields");
        rd(8'h00, v); check("R3 update self-clears", {32'b0, v}, 64'h8000_0000);

        // R5 write inside window, R3 no restart
        mwr(8'h08, 32'h11);
        wr(8'h00, 32'h1);
        s_cfg = p_cfg; s_m = p_m; s_n = p_n; s_d = p_d; m_dirty = 0;
        mwr(8'h08, 32'h22);
        wr(8'h00, 32'h1);
        @(negedge clk);
        check_outs("R4 old value before completion");
        @(negedge clk);
        a_cfg = s_cfg; a_m = s_m; a_n = s_n; a_d = s_d;
        check("R5 snapshot value committed", {56'b0, root_m}, 64'h11);
        rd(8'h00, v); check("R5 flag kept, R3 not restarted", {32'b0, v}, 64'h8000_0040);
        commit_full();
        check("R5 held write in next commit", {56'b0, root_m}, 64'h22);

        // R6 root-off and force
        clk_req = 1'b1; rd(8'h00, v); check("R6 clk_req clears root-off", {32'b0, v}, 64'h0);
        clk_req = 1'b0;
        mwr(8'h00, 32'h2); rd(8'h00, v); check("R6 force on", {32'b0, v}, 64'h2);
        mwr(8'h00, 32'h8000_0002); rd(8'h00, v); check("R6 bit31 not writable", {32'b0, v}, 64'h2);
        mwr(8'h00, 32'h0); rd(8'h00, v); check("R6 force off", {32'b0, v}, 64'h8000_0000);

        // R8, R11 level control and out-of-range index
        for (int i = 0; i < 8; i++) begin
            mwr(8'h1C + 8'(4 * i), $urandom);
            mwr(8'h5C + 8'(4 * i), $urandom);
            mwr(8'h9C + 8'(4 * i), $urandom);
            check_rd("R9 table cfg readback", 8'h1C + 8'(4 * i));
            check_rd("R9 table M readback", 8'h5C + 8'(4 * i));
            check_rd("R9 table N readback", 8'h9C + 8'(4 * i));
        end
        mwr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); check("R8 lvl readback", {32'b0, v}, 64'h1F);
        check_outs("R11 index 15 uses committed");
        mwr(8'h14, 32'h0000_0007);
        check_outs("R10 level 3 overrides");
        mwr(8'h14, 32'h0000_0006);
        check_outs("R11 disabled uses committed");

        // R12 unmapped
        mwr(8'hC0, 32'hFFFF_FFFF);
        mwr(8'h18, 32'hFFFF_FFFF);
        check_rd("R12 unmapped reads zero", 8'hC0);
        check_rd("R12 gap reads zero", 8'h18);
        check_outs("R12 unmapped write no effect");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom % 5);
            if (op == 0) begin
                mwr(8'h14, $urandom);
                check_outs("R10 random level select");
            end else if (op == 1) begin
                mwr(8'h04, $urandom); mwr(8'h08, $urandom);
                mwr(8'h0C, $urandom); mwr(8'h10, $urandom);
                commit_full();
                check_outs("R4 random commit");
            end else begin
                a = 8'($urandom) & 8'hFC;
                if (a != 8'h00) mwr(a, $urandom);
                check_outs("R12 random write outputs");
            end
            a = 8'($urandom) & 8'hFC;
            check_rd("R9 random readback", a);
        end

        finish_up();
    end
endmodule